// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block is the receive side of an asynchronous serial link. A baud divider produces a sampling tick at sixteen times the bit rate. The divider is a coarse prescaler multiplied by a power-of-two factor. The serial input first passes through a two-flop synchronizer and idles high. A falling level starts a frame. The frame is then sampled three times in the middle of every bit, and each bit takes the majority value. Any disagreement between the three samples marks the word as noisy, but the word is still delivered.

A completed word of 8 or 9 data bits, sent least significant bit first, is placed in a holding register and raises a full flag. The ninth bit, when it is enabled, appears on its own output. A read strobe takes the word and clears the flags. The block also reports a framing error, an overrun and noise. An interrupt output combines the full, overrun and framing flags, each gated by its own enable.

Top module: `oversample_rx`

## Requirements
- R1: The sampling tick period is P·2^N clocks. P is chosen by `cfg_pre_sel`: 0→1, 1→3, 2→4, 3→13. N is `cfg_pow` (0..7). A bit lasts 16 ticks.
- R2: The tick on which the input is first seen low while idle is tick 1 of the start bit. Every bit is sampled on its ticks 8, 9 and 10, and its value is the majority of the three samples.
- R3: `noise_flag` is set with a word when the three samples of any of its bits (start, data or stop) disagree. The word is still delivered.
- R4: A start whose majority value is 1 is discarded. The receiver returns to idle and no word is produced.
- R5: With `cfg_nine`=0 a word has 8 data bits. With `cfg_nine`=1 it has 9 data bits. Data bits are sent LSB first. The first eight data bits go to `rx_data`, and the ninth goes to `rx_bit8`. `rx_bit8` is 0 in 8-bit mode.
- R6: A completed word sets `rx_full`. A `rd_strobe` cycle that completes no word clears it.
- R7: When a word completes while `rx_full` is set and there is no `rd_strobe`, `overrun_flag` is set. The stored word and its flags are kept, and the new word is dropped.
- R8: `frame_err_flag` is set with a word whose stop bit has a majority value of 0.
- R9: `irq` is high when any enabled flag is set. The enables are `cfg_ie` bit 0 for full, bit 1 for overrun and bit 2 for framing error.
- R10: After reset all flags are 0, `rx_data` is 0 and `irq` is 0.
- R11: A `rd_strobe` also clears the noise, overrun and framing flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| rx_in | input | 1 | serial input, idle high |
| cfg_pre_sel | input | 2 | coarse prescaler select |
| cfg_pow | input | 3 | power-of-two divider exponent |
| cfg_nine | input | 1 | 9-bit word mode |
| cfg_ie | input | 3 | interrupt enables {frame, overrun, full} |
| rd_strobe | input | 1 | read strobe, one cycle |
| rx_data | output | 8 | received data byte |
| rx_bit8 | output | 1 | ninth data bit |
| rx_full | output | 1 | word waiting |
| noise_flag | output | 1 | samples disagreed in the stored word |
| overrun_flag | output | 1 | word lost while full |
| frame_err_flag | output | 1 | stop bit read as 0 |
| irq | output | 1 | interrupt request |

## Verification
The hardest cases to reach from the ports are a glitch that hits exactly one or two of the three sample ticks, and a start pulse just long enough or just too short to be accepted. With the divider at 1, one clock equals one tick. The bench drives the line on a clock-by-clock grid, so it can place one-clock and two-clock inversions at every phase of a data bit, and start pulses of every length from 1 to 15 ticks. From each position it computes the majority value, the noise flag and whether the word is accepted.

// File: rtl/rx_pkg.sv
package rx_pkg;
  localparam int OVS      = 16;
  localparam int PH_W     = $clog2(OVS);
  localparam int POW_W    = 3;
  localparam int PRE_W    = 5;
  localparam int DIV_W    = PRE_W + (1 << POW_W) - 1;
  localparam int DATA_W   = 8;
  localparam int SYNC_N   = 2;
  localparam logic [PH_W-1:0] SMP_A = PH_W'(OVS/2 - 1);
  localparam logic [PH_W-1:0] SMP_B = PH_W'(OVS/2);
  localparam logic [PH_W-1:0] SMP_C = PH_W'(OVS/2 + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_DATA, ST_STOP} rx_state_t;

  function automatic logic [PRE_W-1:0] pre_factor(input logic [1:0] sel);
    case (sel)
      2'd0:    pre_factor = PRE_W'(1);
      2'd1:    pre_factor = PRE_W'(3);
      2'd2:    pre_factor = PRE_W'(4);
      default: pre_factor = PRE_W'(13);
    endcase
  endfunction
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[0] <= 1'b1;
          else        chain_q[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[i] <= 1'b1;
          else        chain_q[i] <= chain_q[i-1];
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/rx_tick_gen.sv
module rx_tick_gen
  import rx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       pre_sel,
  input  logic [POW_W-1:0] pow,
  output logic             tick
);
  logic [DIV_W-1:0] div_last;
  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    div_last = (DIV_W'(pre_factor(pre_sel)) << pow) - DIV_W'(1);
    tick     = (cnt_q >= div_last);
    cnt_d    = tick ? '0 : cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
endmodule

// File: rtl/rx_frame.sv
module rx_frame
  import rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              line,
  input  logic              nine,
  output logic              done,
  output logic [DATA_W-1:0] dat,
  output logic              b8,
  output logic              noisy,
  output logic              ferr
);
  rx_state_t         st_q, st_d;
  logic [PH_W-1:0]   ph_q, ph_d;
  logic              sa_q, sa_d, sb_q, sb_d;
  logic [3:0]        bc_q, bc_d;
  logic [DATA_W:0]   sh_q, sh_d;
  logic              nz_q, nz_d;
  logic              vote, split;
  logic [3:0]        last_bit;

  assign vote     = (sa_q & sb_q) | (sa_q & line) | (sb_q & line);
  assign split    = ~((sa_q == sb_q) && (sb_q == line));
  assign last_bit = nine ? 4'(DATA_W) : 4'(DATA_W - 1);

  always_comb begin
    st_d = st_q; ph_d = ph_q; sa_d = sa_q; sb_d = sb_q;
    bc_d = bc_q; sh_d = sh_q; nz_d = nz_q; done = 1'b0;
    if (tick) begin
      if (st_q == ST_IDLE) begin
        if (!line) begin
          st_d = ST_START;
          ph_d = PH_W'(1);
          nz_d = 1'b0;
        end
      end else begin
        ph_d = ph_q + PH_W'(1);
        if (ph_q == SMP_A) sa_d = line;
        if (ph_q == SMP_B) sb_d = line;
        if (ph_q == SMP_C) begin
          case (st_q)
            ST_START: begin
              if (vote) st_d = ST_IDLE;
              else begin
                st_d = ST_DATA;
                bc_d = '0;
                nz_d = split;
              end
            end
            ST_DATA: begin
              sh_d = {vote, sh_q[DATA_W:1]};
              nz_d = nz_q | split;
              bc_d = bc_q + 4'd1;
              if (bc_q == last_bit) st_d = ST_STOP;
            end
            ST_STOP: begin
              done = 1'b1;
              st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st_q <= ST_IDLE; ph_q <= '0; sa_q <= 1'b1; sb_q <= 1'b1;
      bc_q <= '0; sh_q <= '0; nz_q <= 1'b0;
    end else begin
      st_q <= st_d; ph_q <= ph_d; sa_q <= sa_d; sb_q <= sb_d;
      bc_q <= bc_d; sh_q <= sh_d; nz_q <= nz_d;
    end

  assign dat   = nine ? sh_q[DATA_W-1:0] : sh_q[DATA_W:1];
  assign b8    = nine & sh_q[DATA_W];
  assign noisy = nz_q | split;
  assign ferr  = ~vote;
endmodule

// File: rtl/rx_hold.sv
module rx_hold
  import rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic [DATA_W-1:0] dat,
  input  logic              b8,
  input  logic              noisy,
  input  logic              ferr,
  input  logic              rd,
  output logic [DATA_W-1:0] data_q,
  output logic              bit8_q,
  output logic              full_q,
  output logic              nf_q,
  output logic              ovr_q,
  output logic              fe_q
);
  logic [DATA_W-1:0] data_d;
  logic bit8_d, full_d, nf_d, ovr_d, fe_d, accept;

  assign accept = done & (~full_q | rd);

  always_comb begin
    data_d = data_q; bit8_d = bit8_q; full_d = full_q;
    nf_d = nf_q; ovr_d = ovr_q; fe_d = fe_q;
    if (accept) begin
      data_d = dat; bit8_d = b8; full_d = 1'b1;
      nf_d = noisy; fe_d = ferr; ovr_d = 1'b0;
    end else if (rd) begin
      full_d = 1'b0; nf_d = 1'b0; fe_d = 1'b0; ovr_d = 1'b0;
    end else if (done) begin
      ovr_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      data_q <= '0; bit8_q <= 1'b0; full_q <= 1'b0;
      nf_q <= 1'b0; ovr_q <= 1'b0; fe_q <= 1'b0;
    end else begin
      data_q <= data_d; bit8_q <= bit8_d; full_q <= full_d;
      nf_q <= nf_d; ovr_q <= ovr_d; fe_q <= fe_d;
    end
endmodule

// File: rtl/oversample_rx.sv
module oversample_rx
  import rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_in,
  input  logic [1:0]        cfg_pre_sel,
  input  logic [POW_W-1:0]  cfg_pow,
  input  logic              cfg_nine,
  input  logic [2:0]        cfg_ie,
  input  logic              rd_strobe,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_bit8,
  output logic              rx_full,
  output logic              noise_flag,
  output logic              overrun_flag,
  output logic              frame_err_flag,
  output logic              irq
);
  logic              line_s, tick;
  logic              w_done, w_b8, w_noisy, w_ferr;
  logic [DATA_W-1:0] w_dat;

  rx_sync #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(rx_in), .q(line_s));

  rx_tick_gen u_tick (
    .clk(clk), .rst_n(rst_n), .pre_sel(cfg_pre_sel), .pow(cfg_pow), .tick(tick));

  rx_frame u_frame (
    .clk(clk), .rst_n(rst_n), .tick(tick), .line(line_s), .nine(cfg_nine),
    .done(w_done), .dat(w_dat), .b8(w_b8), .noisy(w_noisy), .ferr(w_ferr));

  rx_hold u_hold (
    .clk(clk), .rst_n(rst_n), .done(w_done), .dat(w_dat), .b8(w_b8),
    .noisy(w_noisy), .ferr(w_ferr), .rd(rd_strobe),
    .data_q(rx_data), .bit8_q(rx_bit8), .full_q(rx_full),
    .nf_q(noise_flag), .ovr_q(overrun_flag), .fe_q(frame_err_flag));

  assign irq = |(cfg_ie & {frame_err_flag, overrun_flag, rx_full});
endmodule

// File: rtl/rx_checks.sv
module rx_checks (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_strobe,
  input logic       done,
  input logic       w_ferr,
  input logic       nine,
  input logic       full,
  input logic       overrun,
  input logic       ferr,
  input logic       bit8,
  input logic [7:0] data
);
  p_read_clears_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !done) |=> !full);

  p_overrun_keeps_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (full && done && !rd_strobe) |=> (overrun && $stable(data)));

  p_data_only_on_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(data));

  p_frame_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (!full || rd_strobe)) |=> (ferr == $past(w_ferr)));

  p_no_ninth_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !nine && (!full || rd_strobe)) |=> !bit8);

  p_overrun_cleared_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !done) |=> !overrun);
endmodule

bind oversample_rx rx_checks u_rx_checks (
  .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe), .done(w_done),
  .w_ferr(w_ferr), .nine(cfg_nine), .full(rx_full), .overrun(overrun_flag),
  .ferr(frame_err_flag), .bit8(rx_bit8), .data(rx_data));

// File: tb/test_oversample_rx.sv
module test_oversample_rx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_in = 1'b1;
  logic [1:0] cfg_pre_sel = 2'd0;
  logic [2:0] cfg_pow = 3'd0;
  logic       cfg_nine = 1'b0;
  logic [2:0] cfg_ie = 3'd0;
  logic       rd_strobe = 1'b0;
  logic [7:0] rx_data;
  logic       rx_bit8, rx_full, noise_flag, overrun_flag, frame_err_flag, irq;

  int total = 0;
  int bad = 0;
  bit ended = 0;

  always #2.5 clk = ~clk;

  oversample_rx i_oversample_rx (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .cfg_pre_sel(cfg_pre_sel),
    .cfg_pow(cfg_pow), .cfg_nine(cfg_nine), .cfg_ie(cfg_ie), .rd_strobe(rd_strobe),
    .rx_data(rx_data), .rx_bit8(rx_bit8), .rx_full(rx_full), .noise_flag(noise_flag),
    .overrun_flag(overrun_flag), .frame_err_flag(frame_err_flag), .irq(irq));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    rx_in = 1'b1;
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic rd_pulse();
    @(negedge clk) rd_strobe = 1'b1;
    @(negedge clk) rd_strobe = 1'b0;
  endtask

  // one frame; bit gb is inverted on clocks gj..gj+gl-1 of that bit (bit 0 = start)
  task automatic send(input logic [8:0] w, input int nb, input logic stopv,
                      input int gb, input int gj, input int gl, input int dv);
    for (int b = 0; b < nb + 2; b++) begin
      logic v;
      v = (b == 0) ? 1'b0 : (b <= nb) ? w[b-1] : stopv;
      for (int j = 0; j < 16 * dv; j++) begin
        rx_in = v ^ ((b == gb) && (j >= gj) && (j < gj + gl));
        if (dv > 1 && b == nb + 1 && j == 7 * dv + dv / 2) chk("R1 early", 16'(rx_full), 16'd0);
        if (dv > 1 && b == nb + 1 && j == 12 * dv)         chk("R1 on time", 16'(rx_full), 16'd1);
        @(negedge clk);
      end
    end
    rx_in = 1'b1;
  endtask

  function automatic int hits(input int gj, input int gl);
    int c = 0;
    for (int k = 7; k <= 9; k++) if (k >= gj && k < gj + gl) c++;
    return c;
  endfunction

  initial begin
    for (int i = 0; i < 190000; i++) @(posedge clk);
    if (!ended) begin
      ended = 1;
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 full", 16'(rx_full), 0);
    chk("R10 flags", 16'({noise_flag, overrun_flag, frame_err_flag, irq}), 0);
    chk("R10 data", 16'(rx_data), 0);
    rst_n = 1'b1;
    idle(4);

    // R5 R6 R3: every byte in 8-bit mode
    for (int v = 0; v < 256; v++) begin
      send(9'(v), 8, 1'b1, -1, 0, 0, 1);
      idle(4);
      chk("R6 full set", 16'(rx_full), 1);
      chk("R5 data", 16'(rx_data), 16'(v));
      chk("R5 bit8 zero", 16'(rx_bit8), 0);
      chk("R3 no noise", 16'(noise_flag), 0);
      rd_pulse();
      chk("R6 cleared", 16'(rx_full), 0);
    end

    // R5 nine-bit words
    cfg_nine = 1'b1;
    for (int k = 0; k < 16; k++) begin
      logic [8:0] w;
      w = 9'((k * 37 + 5) ^ (k << 5));
      send(w, 9, 1'b1, -1, 0, 0, 1);
      idle(4);
      chk("R5 nine data", 16'(rx_data), 16'(w[7:0]));
      chk("R5 nine bit8", 16'(rx_bit8), 16'(w[8]));
      rd_pulse();
    end
    cfg_nine = 1'b0;

    // R2 R3 glitches inside data bit 3 (frame bit 4) of 0x00
    for (int gl = 1; gl <= 2; gl++)
      for (int gj = 0; gj + gl <= 16; gj++) begin
        int c;
        c = hits(gj, gl);
        send(9'h000, 8, 1'b1, 4, gj, gl, 1);
        idle(4);
        chk("R2 vote", 16'(rx_data), (c >= 2) ? 16'h08 : 16'h00);
        chk("R3 noise", 16'(noise_flag), 16'(c == 1 || c == 2));
        rd_pulse();
      end

    // R4 start pulse length sweep
    for (int len = 1; len <= 15; len++) begin
      rx_in = 1'b0;
      for (int j = 0; j < len; j++) @(negedge clk);
      idle(11 * 16);
      chk("R4 start accept", 16'(rx_full), 16'(len >= 9));
      if (len >= 9) begin
        chk("R4 word", 16'(rx_data), 16'hFF);
        chk("R3 start noise", 16'(noise_flag), 16'(len == 9));
      end
      rd_pulse();
    end

    // R8 framing error and R9 interrupt
    cfg_ie = 3'b100;
    send(9'h03C, 8, 1'b0, -1, 0, 0, 1);
    idle(40);
    chk("R8 frame err", 16'(frame_err_flag), 1);
    chk("R8 data kept", 16'(rx_data), 16'h3C);
    chk("R9 irq frame", 16'(irq), 1);
    cfg_ie = 3'b011;
    @(negedge clk);
    chk("R9 irq full", 16'(irq), 1);
    rd_pulse();
    chk("R11 frame cleared", 16'(frame_err_flag), 0);
    chk("R9 irq low", 16'(irq), 0);

    // R7 overrun
    send(9'h0A1, 8, 1'b1, -1, 0, 0, 1);
    idle(4);
    send(9'h0B2, 8, 1'b1, 4, 7, 1, 1);
    idle(4);
    chk("R7 overrun", 16'(overrun_flag), 1);
    chk("R7 old kept", 16'(rx_data), 16'hA1);
    chk("R7 old noise", 16'(noise_flag), 0);
    cfg_ie = 3'b010;
    @(negedge clk);
    chk("R9 irq overrun", 16'(irq), 1);
    rd_pulse();
    chk("R11 overrun cleared", 16'({rx_full, overrun_flag}), 0);
    cfg_ie = 3'b000;

    // R1 divider rates
    for (int r = 0; r < 3; r++) begin
      int dv;
      cfg_pre_sel = (r == 0) ? 2'd3 : (r == 1) ? 2'd1 : 2'd2;
      cfg_pow     = (r == 0) ? 3'd1 : (r == 1) ? 3'd2 : 3'd0;
      dv          = (r == 0) ? 26 : (r == 1) ? 12 : 4;
      idle(64);
      send(9'(8'h5A ^ 8'(r * 17)), 8, 1'b1, -1, 0, 0, dv);
      idle(4);
      chk("R1 data", 16'(rx_data), 16'(8'h5A ^ 8'(r * 17)));
      rd_pulse();
    end

    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule